// File: doc/BRIEF.md
# SDRAM Mode-Controlled Burst Timing

This block is the device-side burst engine of a synchronous DRAM. A load-mode command captures a configuration word. The word gives the burst length, the read latency in clocks, whether writes are single-location, and an operating-mode field. READ and WRITE commands then produce one column address per beat for an internal storage array. Writes raise a strobe on each beat. Reads pass the array's return data through a latency pipeline and drive an output-enable and a data-valid flag at fixed offsets from the command.

Every beat's column is taken from a sequential count that wraps inside the aligned block of the burst length. A new READ or WRITE cuts short any burst still in progress. Beats already issued still leave the read pipeline on their original timing.

Three flags report illegal configuration: an unsupported burst-length code, an unsupported latency code, and a non-normal operating mode.

Top module: `sdram_burst_timer`

## Requirements
- R1: The `cmd` encoding is 00 NOP, 01 READ, 10 WRITE and 11 LOAD MODE. A LOAD MODE command registers `mode_word` on that edge. Bits [2:0] select the burst length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8. Bits [6:4] select the read latency. Bit 9 selects single-location writes. Bits [8:7] are the operating mode.
- R2: A burst-length code with bit 2 set raises `bl_err` and behaves as length 1. The next LOAD MODE with a legal code clears `bl_err`.
- R3: A latency code other than 2 or 3 raises `lat_err` and leaves the previous latency in force. A LOAD MODE with code 2 or 3 clears `lat_err`.
- R4: Operating-mode bits [8:7] other than 00 raise `op_err`. While `op_err` is high, READ and WRITE are ignored and a running burst is stopped, so no strobe, output-enable or data-valid follows. A LOAD MODE with bits [8:7] = 00 restores normal operation.
- R5: A READ registered at edge n with latency m makes `rd_valid` high from edge n+m for L consecutive cycles, where L is the burst length. Each beat carries the array word read at that beat's column.
- R6: `rd_oe` rises at edge n+m-1, one cycle before the first valid beat. It stays high through the last valid beat and falls one cycle after it.
- R7: Beat i of a burst of length L starting at column c uses column (c with its low log2(L) bits cleared) OR ((c + i) mod L). The first beat is presented in the cycle after the edge that registers the command.
- R8: A WRITE registered at edge n raises `wr_stb` for L consecutive cycles, starting at that edge, with `col_addr` following R7.
- R9: With bit 9 set, each WRITE is one beat at the start column. READs still use the programmed length.
- R10: A READ or WRITE that arrives during a burst ends the old burst. The new command's first beat is presented in the cycle after it is registered. Read beats already issued still produce their data.
- R11: After reset, `wr_stb`, `rd_oe`, `rd_valid` and all three error flags are low. The burst length is 1, the latency is 3 and writes are bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Decoded command (NOP, READ, WRITE, LOAD MODE) |
| mode_word | input | 12 | Configuration word captured on LOAD MODE |
| start_col | input | COL_W (9) | Start column for READ and WRITE |
| arr_rdata | input | DATA_W (16) | Array read data for the current `col_addr` |
| col_addr | output | COL_W (9) | Column of the current beat |
| wr_stb | output | 1 | Write strobe for the current beat |
| rd_oe | output | 1 | Data bus output-enable |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W (16) | Read data |
| bl_err | output | 1 | Unsupported burst-length code loaded |
| lat_err | output | 1 | Unsupported latency code loaded |
| op_err | output | 1 | Non-normal operating mode loaded |

## Verification
The assertions check the output-enable framing on every cycle. Valid data is never presented without the enable, the enable rising means data comes on the next cycle, and the enable is still high in the cycle after data stops. They also check that no write strobe survives a cycle in test mode and that outputs are quiet straight after reset. The exact latency, the wrapped column order, the single-write mode, truncation and the handling of illegal codes depend on what was loaded. Only the bench's directed scenarios can show those, by comparing cycle-by-cycle traces against expected traces built from the requirements.

// File: rtl/sdbt_pkg.sv
`timescale 1ns/1ps
package sdbt_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_LOAD  = 2'b11
    } cmd_e;

    localparam int MODE_W     = 12;
    localparam int F_LEN_LO   = 0;   // 3-bit length code
    localparam int F_LAT_LO   = 4;   // 3-bit latency code
    localparam int F_OPM_LO   = 7;   // 2-bit operating mode
    localparam int F_WSINGLE  = 9;
    localparam int MAX_LEN_LOG = 3;  // longest burst is 8
    localparam int MAX_LAT    = 3;

    typedef struct packed {
        logic [1:0] len_log;   // log2 of burst length
        logic       lat3;      // 1: latency 3, 0: latency 2
        logic       wsingle;
        logic       op_err;
        logic       bl_err;
        logic       lat_err;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{len_log: 2'd0, lat3: 1'b1, wsingle: 1'b0,
                                   op_err: 1'b0, bl_err: 1'b0, lat_err: 1'b0};

    function automatic logic len_code_ok(input logic [2:0] code);
        return !code[2];
    endfunction

    function automatic logic lat_code_ok(input logic [2:0] code);
        return (code == 3'd2) || (code == 3'd3);
    endfunction

endpackage

// File: rtl/sdbt_mode_reg.sv
`timescale 1ns/1ps
module sdbt_mode_reg
    import sdbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [MODE_W-1:0] word,
    output cfg_t              cfg
);
    logic [2:0] len_code;
    logic [2:0] lat_code;
    cfg_t       cfg_next;

    assign len_code = word[F_LEN_LO +: 3];
    assign lat_code = word[F_LAT_LO +: 3];

    always_comb begin
        cfg_next = cfg;
        if (load) begin
            cfg_next.bl_err  = !len_code_ok(len_code);
            cfg_next.len_log = len_code_ok(len_code) ? len_code[1:0] : 2'd0;
            cfg_next.lat_err = !lat_code_ok(lat_code);
            if (lat_code_ok(lat_code))
                cfg_next.lat3 = lat_code[0];
            cfg_next.wsingle = word[F_WSINGLE];
            cfg_next.op_err  = |word[F_OPM_LO +: 2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= CFG_RESET;
        else     cfg <= cfg_next;
    end
endmodule

// File: rtl/sdbt_burst_seq.sv
`timescale 1ns/1ps
module sdbt_burst_seq
    import sdbt_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic             kill,
    input  logic [1:0]       len_log,
    input  logic [COL_W-1:0] col_in,
    output logic [COL_W-1:0] col_addr,
    output logic             beat_rd,
    output logic             beat_wr
);
    localparam int CNT_W = MAX_LEN_LOG;

    logic             active_q, rd_q;
    logic [COL_W-1:0] base_q, off_q, mask_q, mask_new;
    logic [CNT_W-1:0] left_q, left_new;

    assign mask_new = (COL_W'(1) << len_log) - COL_W'(1);
    assign left_new = CNT_W'(((CNT_W+1)'(1) << len_log) - (CNT_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            rd_q     <= 1'b0;
            base_q   <= '0;
            off_q    <= '0;
            mask_q   <= '0;
            left_q   <= '0;
        end else if (kill) begin
            active_q <= 1'b0;
        end else if (start_rd || start_wr) begin
            active_q <= 1'b1;
            rd_q     <= start_rd;
            base_q   <= col_in & ~mask_new;
            off_q    <= col_in & mask_new;
            mask_q   <= mask_new;
            left_q   <= left_new;
        end else if (active_q) begin
            if (left_q == '0) begin
                active_q <= 1'b0;
            end else begin
                left_q <= left_q - CNT_W'(1);
                off_q  <= (off_q + COL_W'(1)) & mask_q;
            end
        end
    end

    assign col_addr = base_q | off_q;
    assign beat_rd  = active_q && rd_q;
    assign beat_wr  = active_q && !rd_q;
endmodule

// File: rtl/sdbt_read_pipe.sv
`timescale 1ns/1ps
module sdbt_read_pipe
    import sdbt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_rd,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        lat,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_oe
);
    localparam int VW = MAX_LAT + 1;
    localparam int VI = $clog2(VW + 1);
    localparam int DI = $clog2(MAX_LAT + 1);

    logic [VW:1]                  v_q;
    logic [MAX_LAT:1][DATA_W-1:0] d_q;
    logic [VI-1:0]                vi;
    logic [DI-1:0]                di;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
            d_q <= '0;
        end else begin
            v_q    <= {v_q[VW-1:1], beat_rd};
            d_q[1] <= rdata;
            for (int k = 2; k <= MAX_LAT; k++)
                d_q[k] <= d_q[k-1];
        end
    end

    assign vi       = VI'(lat);
    assign di       = DI'(lat);
    assign rd_valid = v_q[vi];
    assign rd_data  = d_q[di];
    // enable spans one stage ahead of the data and one stage behind it
    assign rd_oe    = v_q[vi - VI'(1)] | v_q[vi] | v_q[vi + VI'(1)];
endmodule

// File: rtl/sdram_burst_timer.sv
`timescale 1ns/1ps
module sdram_burst_timer
    import sdbt_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [11:0]       mode_word,
    input  logic [COL_W-1:0]  start_col,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [COL_W-1:0]  col_addr,
    output logic              wr_stb,
    output logic              rd_oe,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              bl_err,
    output logic              lat_err,
    output logic              op_err
);
    cmd_e       cmd_t;
    cfg_t       cfg;
    logic       start_rd, start_wr, beat_rd;
    logic [1:0] len_log;
    logic [1:0] lat;

    assign cmd_t = cmd_e'(cmd);

    sdbt_mode_reg u_mode (
        .clk  (clk),
        .rst  (rst),
        .load (cmd_t == CMD_LOAD),
        .word (mode_word),
        .cfg  (cfg)
    );

    assign start_rd = (cmd_t == CMD_READ)  && !cfg.op_err;
    assign start_wr = (cmd_t == CMD_WRITE) && !cfg.op_err;
    assign len_log  = (start_wr && cfg.wsingle) ? 2'd0 : cfg.len_log;
    assign lat      = cfg.lat3 ? 2'd3 : 2'd2;

    sdbt_burst_seq #(.COL_W(COL_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .kill     (cfg.op_err),
        .len_log  (len_log),
        .col_in   (start_col),
        .col_addr (col_addr),
        .beat_rd  (beat_rd),
        .beat_wr  (wr_stb)
    );

    sdbt_read_pipe #(.DATA_W(DATA_W)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .beat_rd  (beat_rd),
        .rdata    (arr_rdata),
        .lat      (lat),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_oe    (rd_oe)
    );

    assign bl_err  = cfg.bl_err;
    assign lat_err = cfg.lat_err;
    assign op_err  = cfg.op_err;
endmodule

// File: rtl/sdbt_checker.sv
`timescale 1ns/1ps
module sdbt_checker (
    input logic clk,
    input logic rst,
    input logic wr_stb,
    input logic rd_valid,
    input logic rd_oe,
    input logic op_err
);
    p_oe_covers_valid_r6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> rd_oe);

    p_oe_leads_data_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_oe) |=> rd_valid);

    p_oe_trails_data_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_valid) |-> rd_oe);

    p_test_mode_no_write_r4: assert property (@(posedge clk) disable iff (rst)
        $past(op_err) |-> !wr_stb);

    p_quiet_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_stb && !rd_valid && !rd_oe && !op_err));
endmodule

bind sdram_burst_timer sdbt_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_stb   (wr_stb),
    .rd_valid (rd_valid),
    .rd_oe    (rd_oe),
    .op_err   (op_err)
);

// File: tb/sdram_burst_timer_bench.sv
`timescale 1ns/1ps
module sdram_burst_timer_bench;
    localparam int COL_W  = 9;
    localparam int DATA_W = 16;
    localparam int N      = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cmd = 2'b00;
    logic [11:0]       mode_word = '0;
    logic [COL_W-1:0]  start_col = '0;
    logic [DATA_W-1:0] arr_rdata;
    logic [COL_W-1:0]  col_addr;
    logic              wr_stb, rd_oe, rd_valid, bl_err, lat_err, op_err;
    logic [DATA_W-1:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    int exp_stb[N], exp_val[N], exp_oe[N], exp_col[N], exp_dat[N];
    int got_stb[N], got_val[N], got_oe[N], got_col[N], got_dat[N];

    always #2 clk = ~clk;

    function automatic int arr_word(input int c);
        return (16'hC300 ^ c) & 16'hFFFF;
    endfunction

    assign arr_rdata = DATA_W'(arr_word(int'(col_addr)));

    sdram_burst_timer u_sdram_burst_timer (
        .clk(clk), .rst(rst), .cmd(cmd), .mode_word(mode_word),
        .start_col(start_col), .arr_rdata(arr_rdata), .col_addr(col_addr),
        .wr_stb(wr_stb), .rd_oe(rd_oe), .rd_valid(rd_valid), .rd_data(rd_data),
        .bl_err(bl_err), .lat_err(lat_err), .op_err(op_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_exp();
        for (int j = 0; j < N; j++) begin
            exp_stb[j] = 0; exp_val[j] = 0; exp_oe[j] = 0;
            exp_col[j] = -1; exp_dat[j] = 0;
        end
    endtask

    // beats issued from cycle c0, cut off at cycle stop
    task automatic add_burst(input int c0, input int len, input int col,
                             input bit rd, input int m, input int stop);
        for (int i = 0; i < len; i++) begin
            int c, cc;
            c = c0 + i;
            if (c >= stop || c + m + 1 >= N) break;
            cc = (col & ~(len - 1)) | ((col + i) & (len - 1));
            exp_col[c] = cc;
            if (rd) begin
                exp_val[c+m] = 1;
                exp_dat[c+m] = arr_word(cc);
                exp_oe[c+m-1] = 1; exp_oe[c+m] = 1; exp_oe[c+m+1] = 1;
            end else begin
                exp_stb[c] = 1;
            end
        end
    endtask

    task automatic load_mode(input logic [11:0] w);
        cmd = 2'b11; mode_word = w;
        @(negedge clk);
        cmd = 2'b00;
        repeat (2) @(negedge clk);
    endtask

    // first command registered at edge n; sample j is cycle n+j; second command driven at sample kb
    task automatic run(input logic [1:0] ca, input int cola,
                       input logic [1:0] cb, input int colb, input int kb,
                       input string req);
        cmd = ca; start_col = COL_W'(cola);
        @(negedge clk);
        for (int j = 0; j < N; j++) begin
            got_stb[j] = int'(wr_stb); got_val[j] = int'(rd_valid);
            got_oe[j] = int'(rd_oe); got_col[j] = int'(col_addr);
            got_dat[j] = int'(rd_data);
            if (j == kb) begin cmd = cb; start_col = COL_W'(colb); end
            else cmd = 2'b00;
            @(negedge clk);
        end
        for (int j = 0; j < N; j++) begin
            chk(got_stb[j] == exp_stb[j], req, $sformatf("wr_stb cyc %0d", j), got_stb[j], exp_stb[j]);
            chk(got_val[j] == exp_val[j], req, $sformatf("rd_valid cyc %0d", j), got_val[j], exp_val[j]);
            chk(got_oe[j] == exp_oe[j], "R6", $sformatf("rd_oe cyc %0d", j), got_oe[j], exp_oe[j]);
            if (exp_col[j] >= 0)
                chk(got_col[j] == exp_col[j], "R7", $sformatf("col_addr cyc %0d", j), got_col[j], exp_col[j]);
            if (exp_val[j] != 0)
                chk(got_dat[j] == exp_dat[j], "R5", $sformatf("rd_data cyc %0d", j), got_dat[j], exp_dat[j]);
        end
    endtask

    task automatic t_reset();
        chk(!wr_stb && !rd_oe && !rd_valid, "R11", "outputs idle", int'({wr_stb, rd_oe, rd_valid}), 0);
        chk(!bl_err && !lat_err && !op_err, "R11", "flags clear", int'({bl_err, lat_err, op_err}), 0);
        clear_exp(); add_burst(0, 1, 9, 1, 3, N);   // reset config: length 1, latency 3
        run(2'b01, 9, 2'b00, 0, -1, "R11");
    endtask

    task automatic t_read_basic();
        load_mode(12'h022);                      // length 4, latency 2
        chk(!bl_err && !lat_err && !op_err, "R1", "flags after legal load", int'({bl_err, lat_err, op_err}), 0);
        clear_exp(); add_burst(0, 4, 5, 1, 2, N);
        run(2'b01, 5, 2'b00, 0, -1, "R5");
        load_mode(12'h033);                      // length 8, latency 3
        clear_exp(); add_burst(0, 8, 13, 1, 3, N);
        run(2'b01, 13, 2'b00, 0, -1, "R1");
    endtask

    task automatic t_write_burst();
        load_mode(12'h022);
        clear_exp(); add_burst(0, 4, 18, 0, 2, N);
        run(2'b10, 18, 2'b00, 0, -1, "R8");
    endtask

    task automatic t_write_single();
        load_mode(12'h222);                      // single writes, length 4, latency 2
        clear_exp(); add_burst(0, 1, 7, 0, 2, N);
        run(2'b10, 7, 2'b00, 0, -1, "R9");
        clear_exp(); add_burst(0, 4, 7, 1, 2, N);
        run(2'b01, 7, 2'b00, 0, -1, "R9");
    endtask

    task automatic t_truncate();
        load_mode(12'h023);                      // length 8, latency 2
        clear_exp(); add_burst(0, 8, 0, 1, 2, 2); add_burst(2, 8, 16, 1, 2, N);
        run(2'b01, 0, 2'b01, 16, 1, "R10");
        clear_exp(); add_burst(0, 8, 0, 0, 2, 1); add_burst(1, 8, 8, 0, 2, N);
        run(2'b10, 0, 2'b10, 8, 0, "R10");
    endtask

    task automatic t_bad_length();
        load_mode(12'h025);                      // length code 101
        chk(bl_err == 1'b1, "R2", "bl_err raised", int'(bl_err), 1);
        clear_exp(); add_burst(0, 1, 6, 1, 2, N);
        run(2'b01, 6, 2'b00, 0, -1, "R2");
    endtask

    task automatic t_bad_latency();
        load_mode(12'h052);                      // latency code 5, length 4
        chk(lat_err == 1'b1, "R3", "lat_err raised", int'(lat_err), 1);
        chk(bl_err == 1'b0, "R2", "bl_err cleared", int'(bl_err), 0);
        clear_exp(); add_burst(0, 4, 1, 1, 2, N);   // latency stays 2
        run(2'b01, 1, 2'b00, 0, -1, "R3");
        load_mode(12'h022);
        chk(lat_err == 1'b0, "R3", "lat_err cleared", int'(lat_err), 0);
    endtask

    task automatic t_test_mode();
        load_mode(12'h0A2);                      // operating mode 01
        chk(op_err == 1'b1, "R4", "op_err raised", int'(op_err), 1);
        clear_exp();
        run(2'b01, 0, 2'b00, 0, -1, "R4");
        run(2'b10, 0, 2'b00, 0, -1, "R4");
        load_mode(12'h022);
        chk(op_err == 1'b0, "R4", "op_err cleared", int'(op_err), 0);
        clear_exp(); add_burst(0, 4, 2, 1, 2, N);
        run(2'b01, 2, 2'b00, 0, -1, "R4");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_write_burst();
        t_write_single();
        t_truncate();
        t_bad_length();
        t_bad_latency();
        t_test_mode();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule